// File: doc/BRIEF.md
# SMBus Host Register Sequencer

This block is the byte-wide register front end of an SMBus host controller. Software reaches it through a simple write strobe, a small offset and a byte of write data. Reads are combinational. From those registers the block builds the request that it hands to a separate byte-level bus engine: the transaction type, the target address with its direction bit, the command byte and the two outgoing data bytes. It also carries the checksum and block-buffer mode enables.

The block keeps the host status byte. A busy flag is high while a request is outstanding. One sticky flag per outcome records how the request ended: done, no acknowledge, collision or failure. A further sticky flag records byte completion. Software clears these flags by writing ones to them. A new start is refused while any low status flag is still set. A kill bit in the control byte aborts a running request and reports a failure. When a read transaction ends successfully, its returned bytes are captured into the data registers.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00 at offsets 0, 2, 3, 4, 5, 6, 7, 8, 12 and 13, and eng_go, eng_abort, eng_pec and eng_blkbuf are low.
- R2: Offsets 3 (command), 4 (address), 5 (data0), 6 (data1), 7 (block data) and 8 (checksum byte) read back the last byte written. The control byte at offset 2 reads back what was written, except that bit 6 always reads 0.
- R3: A control write with bit 6 (start) set and bit 1 clear, made while status bits [4:0] are all 0, raises eng_go for exactly one cycle after the write edge. Status bit 0 (busy) reads 1 from that same cycle. eng_kind equals control bits [4:2], eng_target equals address bits [7:1] and eng_rnw equals address bit 0.
- R4: A start written while any of status bits [4:0] is set is ignored: eng_go stays low and the status byte is unchanged.
- R5: An ev_done pulse while busy clears busy and sets status bit 1 (0x02) at the same clock edge.
- R6: While busy, ev_nack sets status bit 2 (0x04), ev_coll sets bit 3 (0x08) and ev_fail sets bit 4 (0x10). Each of them clears busy at the same edge and leaves bit 1 clear.
- R7: Writing offset 0 clears each of status bits 7, 4, 3, 2 and 1 whose written bit is 1, and leaves every other bit unchanged. Writing back the value just read clears all of them. Writes never change busy.
- R8: A control write with bit 1 (kill) set while busy pulses eng_abort for one cycle, clears busy and sets status bit 4 at the same edge. A kill written while idle changes no status bit and gives no pulse.
- R9: On a successful completion with address bit 0 = 1, data0 takes ev_rx0 when the type code (control bits [4:2]) is 1 (byte), 2 (byte-data) or 3 (word). data1 takes ev_rx1 only for type 3. All other types and all writes (bit 0 = 0) leave both data registers unchanged.
- R10: ev_byte while busy sets status bit 7 (0x80). ev_byte and every other engine event while idle leave the status byte unchanged.
- R11: Auxiliary control at offset 13 stores bits [1:0] and reads 0 in bits [7:2]. Bit 0 or control bit 7 drives eng_pec, and bit 1 drives eng_blkbuf. Offset 12 always reads 0.
- R12: A control write with start and kill both set starts nothing: eng_go stays low and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register offset |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data for reg_addr |
| eng_go | output | 1 | One-cycle request launch to the bus engine |
| eng_abort | output | 1 | One-cycle abort of the running request |
| eng_kind | output | 3 | Transaction type code |
| eng_target | output | 7 | Target device address |
| eng_rnw | output | 1 | 1 = read, 0 = write |
| eng_cmd | output | DW (8) | Command byte |
| eng_tx0 | output | DW (8) | First outgoing data byte |
| eng_tx1 | output | DW (8) | Second outgoing data byte |
| eng_pec | output | 1 | Checksum generation enable |
| eng_blkbuf | output | 1 | Block buffer mode enable |
| ev_done | input | 1 | Engine: request finished cleanly |
| ev_nack | input | 1 | Engine: target did not acknowledge |
| ev_coll | input | 1 | Engine: bus collision |
| ev_fail | input | 1 | Engine: request failed |
| ev_byte | input | 1 | Engine: one byte transferred |
| ev_rx0 | input | DW (8) | Engine: first received byte |
| ev_rx1 | input | DW (8) | Engine: second received byte |

## Verification
The bench builds the block with its defaults: byte-wide data, a four-bit offset and the auxiliary register present. With those values every one of the eight type codes can be driven in both directions. This checks the launch fields and the capture rule for each type. Every ending event is combined with and without a byte-done event. For each combination the bench tries a refused start, then a clear mask that touches only unset bits, then the read-back clear. Kill in both the busy and idle states, the start-plus-kill write and the auxiliary bits close the sweep.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
   localparam int unsigned OFS_STAT   = 0;
   localparam int unsigned OFS_CTRL   = 2;
   localparam int unsigned OFS_CMD    = 3;
   localparam int unsigned OFS_ADDR   = 4;
   localparam int unsigned OFS_DAT0   = 5;
   localparam int unsigned OFS_DAT1   = 6;
   localparam int unsigned OFS_BLK    = 7;
   localparam int unsigned OFS_PEC    = 8;
   localparam int unsigned OFS_AUXSTS = 12;
   localparam int unsigned OFS_AUXCTL = 13;

   localparam int unsigned CB_KILL  = 1;
   localparam int unsigned CB_START = 6;
   localparam int unsigned CB_PEC   = 7;

   localparam logic [7:0] STAT_W1C  = 8'h9E;
   localparam logic [7:0] STAT_GATE = 8'h1F;

   typedef enum logic [2:0] {
      XK_QUICK = 3'd0,
      XK_BYTE  = 3'd1,
      XK_BDATA = 3'd2,
      XK_WORD  = 3'd3,
      XK_PCALL = 3'd4,
      XK_BLOCK = 3'd5,
      XK_I2CBK = 3'd6,
      XK_RSVD  = 3'd7
   } xfer_kind_e;

   typedef struct packed {
      logic done;
      logic nack;
      logic coll;
      logic fail;
      logic byte_ev;
   } eng_evt_t;
endpackage

// File: rtl/smb_stat_flags.sv
module smb_stat_flags
   import smb_host_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_we,
   input  logic [DW-1:0] clr_bits,
   input  logic          go_req,
   input  logic          kill_req,
   input  eng_evt_t      evt,
   output logic [DW-1:0] stat_q
);
   localparam logic [DW-1:0] W1C = DW'(STAT_W1C);

   logic          busy_q;
   logic [DW-1:0] flag_q;
   logic [DW-1:0] set_v;
   logic [DW-1:0] clr_v;
   logic          any_err;
   logic          ending;

   assign any_err = evt.nack | evt.coll | evt.fail;
   assign ending  = busy_q & (evt.done | any_err | kill_req);

   always_comb begin
      set_v    = '0;
      set_v[7] = busy_q & evt.byte_ev;
      set_v[4] = busy_q & (evt.fail | kill_req);
      set_v[3] = busy_q & evt.coll & ~kill_req;
      set_v[2] = busy_q & evt.nack & ~kill_req;
      set_v[1] = busy_q & evt.done & ~any_err & ~kill_req;
      clr_v    = clr_we ? (clr_bits & W1C) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         flag_q <= '0;
      end else begin
         flag_q <= ((flag_q & ~clr_v) | set_v) & W1C;
         if (go_req)
            busy_q <= 1'b1;
         else if (ending)
            busy_q <= 1'b0;
      end
   end

   assign stat_q = (flag_q & W1C) | {{(DW-1){1'b0}}, busy_q};
endmodule

// File: rtl/smb_launch.sv
module smb_launch
   import smb_host_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_we,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] stat,
   output logic [DW-1:0] ctrl_q,
   output logic          go_req,
   output logic          kill_req,
   output logic          go_q,
   output logic          abort_q
);
   localparam logic [DW-1:0] GATE  = DW'(STAT_GATE);
   localparam logic [DW-1:0] KEEP  = ~(DW'(1) << CB_START);

   logic blocked;
   assign blocked  = |(stat & GATE);
   assign go_req   = ctrl_we & wdata[CB_START] & ~wdata[CB_KILL] & ~blocked;
   assign kill_req = ctrl_we & wdata[CB_KILL] & stat[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         go_q    <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         if (ctrl_we)
            ctrl_q <= wdata & KEEP;
         go_q    <= go_req;
         abort_q <= kill_req;
      end
   end
endmodule

// File: rtl/smb_data_regs.sv
module smb_data_regs
   import smb_host_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 4,
   parameter bit HAS_AUX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          cap_en,
   input  xfer_kind_e    kind,
   input  logic [DW-1:0] rx0,
   input  logic [DW-1:0] rx1,
   output logic [DW-1:0] cmd_q,
   output logic [DW-1:0] adr_q,
   output logic [DW-1:0] d0_q,
   output logic [DW-1:0] d1_q,
   output logic [DW-1:0] blk_q,
   output logic [DW-1:0] pec_q,
   output logic [1:0]    aux_q
);
   logic cap0;
   logic cap1;

   assign cap0 = cap_en & ((kind == XK_BYTE) | (kind == XK_BDATA) | (kind == XK_WORD));
   assign cap1 = cap_en & (kind == XK_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         adr_q <= '0;
         d0_q  <= '0;
         d1_q  <= '0;
         blk_q <= '0;
         pec_q <= '0;
      end else begin
         if (we && addr == AW'(OFS_CMD))  cmd_q <= wdata;
         if (we && addr == AW'(OFS_ADDR)) adr_q <= wdata;
         if (we && addr == AW'(OFS_BLK))  blk_q <= wdata;
         if (we && addr == AW'(OFS_PEC))  pec_q <= wdata;
         if (cap0)
            d0_q <= rx0;
         else if (we && addr == AW'(OFS_DAT0))
            d0_q <= wdata;
         if (cap1)
            d1_q <= rx1;
         else if (we && addr == AW'(OFS_DAT1))
            d1_q <= wdata;
      end
   end

   generate
      if (HAS_AUX) begin : g_aux
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               aux_q <= '0;
            else if (we && addr == AW'(OFS_AUXCTL))
               aux_q <= wdata[1:0];
         end
      end else begin : g_noaux
         assign aux_q = 2'b00;
      end
   endgenerate
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
   import smb_host_pkg::*;
#(
   parameter int DW      = 8,
   parameter int AW      = 4,
   parameter bit HAS_AUX = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          eng_go,
   output logic          eng_abort,
   output logic [2:0]    eng_kind,
   output logic [6:0]    eng_target,
   output logic          eng_rnw,
   output logic [DW-1:0] eng_cmd,
   output logic [DW-1:0] eng_tx0,
   output logic [DW-1:0] eng_tx1,
   output logic          eng_pec,
   output logic          eng_blkbuf,
   input  logic          ev_done,
   input  logic          ev_nack,
   input  logic          ev_coll,
   input  logic          ev_fail,
   input  logic          ev_byte,
   input  logic [DW-1:0] ev_rx0,
   input  logic [DW-1:0] ev_rx1
);
   generate
      if (DW != 8) begin : g_bad_dw
         $error("smb_host_regs: DW must be 8, bit positions are fixed");
      end
      if (AW < 4) begin : g_bad_aw
         $error("smb_host_regs: AW must reach offset 13");
      end
   endgenerate

   logic [DW-1:0] stat_q;
   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] cmd_q, adr_q, d0_q, d1_q, blk_q, pec_q;
   logic [1:0]    aux_q;
   logic          go_req, kill_req, cap_en;
   eng_evt_t      evt;

   assign evt = '{done: ev_done, nack: ev_nack, coll: ev_coll,
                  fail: ev_fail, byte_ev: ev_byte};

   smb_launch #(.DW(DW)) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (reg_we && reg_addr == AW'(OFS_CTRL)),
      .wdata    (reg_wdata),
      .stat     (stat_q),
      .ctrl_q   (ctrl_q),
      .go_req   (go_req),
      .kill_req (kill_req),
      .go_q     (eng_go),
      .abort_q  (eng_abort)
   );

   smb_stat_flags #(.DW(DW)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_we   (reg_we && reg_addr == AW'(OFS_STAT)),
      .clr_bits (reg_wdata),
      .go_req   (go_req),
      .kill_req (kill_req),
      .evt      (evt),
      .stat_q   (stat_q)
   );

   assign cap_en = stat_q[0] & ev_done & ~ev_nack & ~ev_coll & ~ev_fail
                   & ~kill_req & adr_q[0];

   smb_data_regs #(.DW(DW), .AW(AW), .HAS_AUX(HAS_AUX)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .cap_en (cap_en),
      .kind   (xfer_kind_e'(ctrl_q[4:2])),
      .rx0    (ev_rx0),
      .rx1    (ev_rx1),
      .cmd_q  (cmd_q),
      .adr_q  (adr_q),
      .d0_q   (d0_q),
      .d1_q   (d1_q),
      .blk_q  (blk_q),
      .pec_q  (pec_q),
      .aux_q  (aux_q)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(OFS_STAT):   reg_rdata = stat_q;
         AW'(OFS_CTRL):   reg_rdata = ctrl_q;
         AW'(OFS_CMD):    reg_rdata = cmd_q;
         AW'(OFS_ADDR):   reg_rdata = adr_q;
         AW'(OFS_DAT0):   reg_rdata = d0_q;
         AW'(OFS_DAT1):   reg_rdata = d1_q;
         AW'(OFS_BLK):    reg_rdata = blk_q;
         AW'(OFS_PEC):    reg_rdata = pec_q;
         AW'(OFS_AUXSTS): reg_rdata = '0;
         AW'(OFS_AUXCTL): reg_rdata = {{(DW-2){1'b0}}, aux_q};
         default:         reg_rdata = '0;
      endcase
   end

   assign eng_kind   = ctrl_q[4:2];
   assign eng_target = adr_q[7:1];
   assign eng_rnw    = adr_q[0];
   assign eng_cmd    = cmd_q;
   assign eng_tx0    = d0_q;
   assign eng_tx1    = d1_q;
   assign eng_pec    = ctrl_q[CB_PEC] | aux_q[0];
   assign eng_blkbuf = aux_q[1];
endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_we,
   input logic [AW-1:0] reg_addr,
   input logic [DW-1:0] reg_wdata,
   input logic          eng_go,
   input logic          eng_abort,
   input logic          ev_byte,
   input logic [DW-1:0] stat_q
);
   // R3: a launch pulse coincides with busy and lasts one cycle
   a_r3_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> stat_q[0]);
   a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |=> !eng_go);

   // R4: start refused while a gating flag is set
   a_r4_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(2) && reg_wdata[6] && (stat_q[4:0] != 5'd0))
      |=> !eng_go);

   // R5/R6: busy never falls without an outcome flag
   a_r5_outcome_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_q[0]) |-> (stat_q[4:1] != 4'd0));

   // R8: abort pulse shows failed with busy low
   a_r8_abort_fails: assert property (@(posedge clk) disable iff (!rst_n)
      eng_abort |-> (stat_q[4] && !stat_q[0]));

   // R10: byte event while idle does not raise byte-done
   a_r10_idle_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[0] && ev_byte) |=> !$rose(stat_q[7]));
endmodule

bind smb_host_regs smb_host_regs_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/test_smb_host_regs.sv
module test_smb_host_regs;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       eng_go, eng_abort, eng_rnw, eng_pec, eng_blkbuf;
   logic [2:0] eng_kind;
   logic [6:0] eng_target;
   logic [7:0] eng_cmd, eng_tx0, eng_tx1;
   logic       ev_done = 0, ev_nack = 0, ev_coll = 0, ev_fail = 0, ev_byte = 0;
   logic [7:0] ev_rx0 = '0, ev_rx1 = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_host_regs i_smb_host_regs (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 4'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   // sel: 0 done, 1 nack, 2 coll, 3 fail, 4 byte
   task automatic ev(input int sel, input int r0, input int r1);
      ev_rx0 = 8'(r0); ev_rx1 = 8'(r1);
      ev_done = (sel == 0); ev_nack = (sel == 1); ev_coll = (sel == 2);
      ev_fail = (sel == 3); ev_byte = (sel == 4);
      @(negedge clk);
      {ev_done, ev_nack, ev_coll, ev_fail, ev_byte} = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int v;
      int ofs[10] = '{0, 2, 3, 4, 5, 6, 7, 8, 12, 13};
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      foreach (ofs[i]) begin rd(ofs[i], v); chk("R1 reset read", v, 0); end
      chk("R1 go", eng_go, 0); chk("R1 abort", eng_abort, 0);
      chk("R1 pec", eng_pec, 0); chk("R1 blkbuf", eng_blkbuf, 0);

      // R2 readback
      for (int k = 3; k <= 8; k++) begin
         wr(k, 8'h11 * k + 3); rd(k, v); chk("R2 readback", v, (8'h11 * k + 3) & 8'hFF);
      end
      wr(2, 8'h9E); rd(2, v); chk("R2 ctrl readback", v, 8'h9E);
      rd(0, v); chk("R8 idle kill no status", v, 0);
      chk("R8 idle kill no abort", eng_abort, 0);
      wr(2, 8'h00);

      // R3, R5, R9: every type code, both directions
      for (int k = 0; k < 8; k++) begin
         for (int rw = 0; rw < 2; rw++) begin
            int tgt, r0, r1, e0, e1;
            tgt = (k * 13 + rw * 5 + 1) & 8'h7F;
            r0 = (k * 17 + rw * 3 + 1) & 8'hFF; r1 = (~r0) & 8'hFF;
            wr(5, 8'hA5); wr(6, 8'h5A);
            wr(4, (tgt << 1) | rw);
            wr(2, (k << 2) | 8'h40);
            chk("R3 go pulse", eng_go, 1);
            chk("R3 kind", eng_kind, k);
            chk("R3 target", eng_target, tgt);
            chk("R3 rnw", eng_rnw, rw);
            rd(0, v); chk("R3 busy", v, 8'h01);
            @(negedge clk);
            chk("R3 go one cycle", eng_go, 0);
            ev(0, r0, r1);
            rd(0, v); chk("R5 done flag with busy low", v, 8'h02);
            e0 = (rw == 1 && k >= 1 && k <= 3) ? r0 : 8'hA5;
            e1 = (rw == 1 && k == 3) ? r1 : 8'h5A;
            rd(5, v); chk("R9 data0", v, e0);
            rd(6, v); chk("R9 data1", v, e1);
            wr(0, 8'h02);
            rd(0, v); chk("R7 clear done", v, 0);
         end
      end

      // R4, R6, R7, R10: each ending with and without byte-done
      for (int e = 0; e < 4; e++) begin
         for (int b = 0; b < 2; b++) begin
            int exp_st, unset;
            wr(4, 8'h20);
            wr(2, 8'h44);
            if (b == 1) ev(4, 0, 0);
            ev(e, 0, 0);
            exp_st = (b << 7) | (e == 0 ? 8'h02 : e == 1 ? 8'h04 : e == 2 ? 8'h08 : 8'h10);
            rd(0, v); chk("R6 ending flags", v, exp_st);
            wr(2, 8'h44);
            chk("R4 start refused", eng_go, 0);
            rd(0, v); chk("R4 status unchanged", v, exp_st);
            ev(4, 0, 0);
            rd(0, v); chk("R10 idle event ignored", v, exp_st);
            unset = (~exp_st) & 8'hFF;
            wr(0, unset);
            rd(0, v); chk("R7 unset mask no effect", v, exp_st);
            wr(0, v);
            rd(0, v); chk("R7 readback clear", v, 0);
         end
      end

      // R8 kill while busy
      wr(2, 8'h40);
      wr(0, 8'hFF);
      rd(0, v); chk("R7 busy survives write", v, 8'h01);
      wr(2, 8'h02);
      chk("R8 abort pulse", eng_abort, 1);
      rd(0, v); chk("R8 failed set", v, 8'h10);
      @(negedge clk);
      chk("R8 abort one cycle", eng_abort, 0);
      wr(2, 8'h00); wr(0, 8'h10);

      // R12 start and kill together
      wr(2, 8'h42);
      chk("R12 no go", eng_go, 0);
      rd(0, v); chk("R12 not busy", v, 0);
      wr(2, 8'h00);

      // R11 auxiliary control
      wr(13, 8'hFF);
      rd(13, v); chk("R11 aux readback", v, 8'h03);
      chk("R11 pec from aux", eng_pec, 1);
      chk("R11 blkbuf", eng_blkbuf, 1);
      rd(12, v); chk("R11 aux status zero", v, 0);
      wr(13, 8'h00);
      chk("R11 pec off", eng_pec, 0);
      wr(2, 8'h80);
      chk("R11 pec from ctrl", eng_pec, 1);
      chk("R11 blkbuf off", eng_blkbuf, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule